// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block sits on the host side of a parallel flash device and decides when a program or erase operation inside the flash has ended. Software or a sequencer pulses `start` with the polled address, the byte that was written and a method choice. The poller then sends status reads through a valid/ready request channel and takes the returned bytes back over a valid/ready response channel. It judges each status byte and stops with a pass or a fail verdict.

Two methods are offered. Data polling compares bit 7 of each status byte with bit 7 of the expected byte. For a chip erase the expected byte is FFh, so the expected bit 7 is 1 and any address can be polled. Toggle polling compares bit 6 of consecutive reads. In both methods bit 5 is the error flag. When bit 5 is set, the poller does not end at once. It makes one more check (one read for data polling, a fresh pair of reads for toggle polling), and that check decides between pass and fail. A poll limit ends a stuck operation with fail plus timeout. On any fail the block can send one write of F0h, which is the flash's return-to-read command, before it reports.

Back-pressure rules: a request stays valid, with stable address, write flag and write data, until `req_ready` is seen high at a clock edge. At most one read is outstanding. `rsp_ready` is high only while a read is outstanding, and a response byte is taken only on a cycle where `rsp_valid` and `rsp_ready` are both high. A write expects no response.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fail`, `timeout`, `req_valid` and `rsp_ready` are all 0.
- R2: `start` is taken only while `busy` is 0. At that point `poll_addr`, `expect_byte`, `mode_toggle` (0 = data polling, 1 = toggle polling) and `reset_on_fail` are captured. A `start` pulse or input change while busy has no effect, and `busy` returns to 0 after `done`.
- R3: A request holds `req_valid`, `req_addr`, `req_write` and `req_wdata` stable until a cycle with `req_ready` high. Reads go to the captured address with `req_write` = 0. No new request is raised while a read is outstanding.
- R4: In data polling, a status byte whose bit 7 equals bit 7 of the captured expected byte ends with pass. For erase, expected FFh means bit 7 = 1.
- R5: In data polling, a byte with bit 7 different and bit 5 = 0 causes another read.
- R6: In data polling, a byte with bit 7 different and bit 5 = 1 causes exactly one confirm read. If its bit 7 matches, the result is pass; otherwise it is fail.
- R7: In toggle polling, the first read is only a reference. Any later read whose bit 6 equals bit 6 of the read before it ends with pass.
- R8: In toggle polling, if bit 6 toggled and bit 5 = 0, reading continues. If bit 6 toggled and bit 5 = 1, two more reads are made: pass if their bit 6 values are equal, fail otherwise.
- R9: After MAX_POLLS read-again decisions without a verdict, the block ends with fail and timeout. It has then issued exactly MAX_POLLS reads.
- R10: On fail with `reset_on_fail` captured as 1, exactly one write (`req_write` = 1, `req_wdata` = F0h, `req_addr` = captured address) is made before `done`. On pass, or with the option at 0, no write is made.
- R11: `done` is a one-cycle pulse in the cycle after the final handshake (the deciding response, or the reset write). Exactly one of `pass`/`fail` is set, and the flags hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken only when idle |
| mode_toggle | input | 1 | 0 = data polling, 1 = toggle polling |
| reset_on_fail | input | 1 | Send the F0h write on fail |
| poll_addr | input | AW | Address to poll |
| expect_byte | input | 8 | Byte written (FFh for erase) |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by the bus side |
| req_addr | output | AW | Request address |
| req_write | output | 1 | 1 = write, 0 = read |
| req_wdata | output | 8 | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Poller can take read data |
| rsp_data | input | 8 | Status byte returned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| pass | output | 1 | Verdict: completed |
| fail | output | 1 | Verdict: failed |
| timeout | output | 1 | Fail was caused by the poll limit |

## Verification
A request becomes visible one cycle after `start`, or one cycle after the response that asked for another read. `done` with its verdict is due exactly one cycle after the deciding response handshake or the reset-write handshake. The bench drives all inputs on falling edges and predicts each handshake from the levels seen there. It logs the cycle index of the last handshake and requires `done` at the very next falling edge. It sweeps loop counts, error endings, expected bit values, response latency and ready stalls, and compares read counts, write counts and flags with values worked out from how each script was built.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_RSTW, ST_DONE
  } fdp_state_e;

  typedef enum logic [2:0] {
    VD_AGAIN, VD_CONFIRM, VD_PAIR_NEXT, VD_PASS, VD_FAIL
  } fdp_verdict_e;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int ERR_BIT  = 5;
  localparam logic [7:0] RETURN_READ_CMD = 8'hF0;
endpackage

// File: rtl/fdp_judge.sv
module fdp_judge
  import fdp_pkg::*;
(
  input  logic         mode_toggle,
  input  logic         exp_bit,
  input  logic [7:0]   status,
  input  logic         prev_tog,
  input  logic         have_prev,
  input  logic [1:0]   confirm_ph,
  output fdp_verdict_e verdict
);
  logic match, same, err;

  always_comb begin
    match = (status[POLL_BIT] == exp_bit);
    same  = (status[TOG_BIT] == prev_tog);
    err   = status[ERR_BIT];
    verdict = VD_AGAIN;
    if (!mode_toggle) begin
      if (confirm_ph != 2'd0)  verdict = match ? VD_PASS : VD_FAIL;   // R6
      else if (match)          verdict = VD_PASS;                     // R4
      else if (err)            verdict = VD_CONFIRM;                  // R6
      else                     verdict = VD_AGAIN;                    // R5
    end else begin
      case (confirm_ph)
        2'd1:    verdict = VD_PAIR_NEXT;                              // R8
        2'd2:    verdict = same ? VD_PASS : VD_FAIL;                  // R8
        default: begin
          if (!have_prev)  verdict = VD_AGAIN;                        // R7
          else if (same)   verdict = VD_PASS;                         // R7
          else if (err)    verdict = VD_CONFIRM;                      // R8
          else             verdict = VD_AGAIN;                        // R8
        end
      endcase
    end
  end
endmodule

// File: rtl/fdp_poll_count.sv
module fdp_poll_count #(
  parameter int MAX_POLLS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last_try
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign last_try = (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bump && !clear |-> cnt < LAST) // R9
    else $error("poll count stepped past limit");
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fdp_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MAX_POLLS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_toggle,
  input  logic          reset_on_fail,
  input  logic [AW-1:0] poll_addr,
  input  logic [7:0]    expect_byte,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          req_write,
  output logic [7:0]    req_wdata,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [7:0]    rsp_data,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          timeout
);
  fdp_state_e   state;
  fdp_verdict_e verdict;
  logic          mode_q, rof_q, exp_q, prev_q, have_prev_q;
  logic [1:0]    cph_q;
  logic [AW-1:0] addr_q;
  logic          pass_q, fail_q, to_q;
  logic          take_start, rsp_hs, req_hs, last_try, bump;

  assign take_start = (state == ST_IDLE) && start;
  assign rsp_hs     = (state == ST_WAIT) && rsp_valid;
  assign req_hs     = req_valid && req_ready;
  assign bump       = rsp_hs && (verdict == VD_AGAIN) && !last_try;

  fdp_judge judge_i (
    .mode_toggle (mode_q),
    .exp_bit     (exp_q),
    .status      (rsp_data),
    .prev_tog    (prev_q),
    .have_prev   (have_prev_q),
    .confirm_ph  (cph_q),
    .verdict     (verdict)
  );

  fdp_poll_count #(.MAX_POLLS(MAX_POLLS)) count_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (take_start),
    .bump     (bump),
    .last_try (last_try)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mode_q      <= 1'b0;
      rof_q       <= 1'b0;
      exp_q       <= 1'b0;
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
      cph_q       <= 2'd0;
      addr_q      <= '0;
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
      to_q        <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (take_start) begin                       // R2
          mode_q      <= mode_toggle;
          rof_q       <= reset_on_fail;
          exp_q       <= expect_byte[POLL_BIT];
          addr_q      <= poll_addr;
          have_prev_q <= 1'b0;
          cph_q       <= 2'd0;
          pass_q      <= 1'b0;
          fail_q      <= 1'b0;
          to_q        <= 1'b0;
          state       <= ST_REQ;
        end
        ST_REQ: if (req_hs) state <= ST_WAIT;                  // R3
        ST_WAIT: if (rsp_hs) begin
          prev_q      <= rsp_data[TOG_BIT];
          have_prev_q <= 1'b1;
          case (verdict)
            VD_AGAIN: begin
              if (last_try) begin                              // R9
                fail_q <= 1'b1;
                to_q   <= 1'b1;
                state  <= rof_q ? ST_RSTW : ST_DONE;
              end else begin
                state  <= ST_REQ;
              end
            end
            VD_CONFIRM: begin
              cph_q <= 2'd1;
              state <= ST_REQ;
            end
            VD_PAIR_NEXT: begin
              cph_q <= 2'd2;
              state <= ST_REQ;
            end
            VD_PASS: begin
              pass_q <= 1'b1;
              state  <= ST_DONE;
            end
            default: begin                                     // R10
              fail_q <= 1'b1;
              state  <= rof_q ? ST_RSTW : ST_DONE;
            end
          endcase
        end
        ST_RSTW: if (req_hs) state <= ST_DONE;                 // R10
        default: state <= ST_IDLE;                             // R11
      endcase
    end
  end

  assign req_valid = (state == ST_REQ) || (state == ST_RSTW);
  assign req_write = (state == ST_RSTW);
  assign req_addr  = addr_q;
  assign req_wdata = (state == ST_RSTW) ? RETURN_READ_CMD : 8'h00;
  assign rsp_ready = (state == ST_WAIT);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign pass      = pass_q;
  assign fail      = fail_q;
  assign timeout   = to_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)) // R3
    else $error("request dropped or changed under back-pressure");

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_valid) // R3
    else $error("request raised while a read is outstanding");

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({pass, fail}) == 1) // R11
    else $error("done without a single verdict");

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy) // R11
    else $error("done longer than one cycle");

  AST_TIMEOUT_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> fail && !pass) // R9
    else $error("timeout without fail");

  AST_WRITE_ONLY_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> fail && req_wdata == 8'hF0) // R10
    else $error("reset write without a fail");

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy && $stable(pass) && $stable(fail)) // R2
    else $error("idle poller changed without start");
endmodule

// File: tb/flash_done_poller_tb_top.sv
module flash_done_poller_tb_top;
  localparam int AW   = 8;
  localparam int MAXP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, mode_toggle = 1'b0, reset_on_fail = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic [7:0]    expect_byte = 8'h00;
  logic          req_valid, req_ready = 1'b0, req_write;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_wdata;
  logic          rsp_valid = 1'b0, rsp_ready;
  logic [7:0]    rsp_data = 8'h00;
  logic          busy, done, pass, fail, timeout;

  int checks = 0, errors = 0;
  logic [7:0] script [0:15];

  always #5 clk = ~clk;

  flash_done_poller #(.AW(AW), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_toggle(mode_toggle),
    .reset_on_fail(reset_on_fail), .poll_addr(poll_addr), .expect_byte(expect_byte),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .timeout(timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one operation against the current script
  task automatic run_case(input bit tog, input bit e7, input int nb, input int endk,
                          input bit rof, input bit stall, input int lat);
    int exp_reads, reads, writes, cyc, pend, last_hs, ridx;
    bit exp_pass, exp_to, got_done, rsp_hs_prev, bad_wr;
    logic [AW-1:0] addr;
    addr = AW'(nb * 17 + endk * 5 + 3);
    // expected outcome from construction of the script
    if (!tog) begin
      exp_to = (nb >= MAXP);
      exp_reads = exp_to ? MAXP : ((endk == 0) ? nb + 1 : nb + 2);
    end else begin
      exp_to = (nb + 1 >= MAXP);
      exp_reads = exp_to ? MAXP : ((endk == 0) ? nb + 2 : nb + 4);
    end
    exp_pass = !exp_to && (endk != 2);

    @(negedge clk);
    mode_toggle = tog; reset_on_fail = rof; poll_addr = addr;
    expect_byte = e7 ? 8'hFF : 8'h3C;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expect_byte = ~expect_byte;   // change after capture, must not matter (R2)
    mode_toggle = ~tog;
    reads = 0; writes = 0; cyc = 0; pend = 0; last_hs = -10; ridx = 0;
    got_done = 0; rsp_hs_prev = 0; bad_wr = 0;
    while (!got_done && cyc < 300) begin
      if (rsp_hs_prev) begin rsp_valid = 1'b0; ridx++; rsp_hs_prev = 0; end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin rsp_valid = 1'b1; rsp_data = script[ridx]; end
      end
      start = (cyc == 2);          // pulse while busy: ignored (R2)
      req_ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (done) begin
        got_done = 1;
        chk(cyc == last_hs + 1, "R11 done timing", cyc, last_hs + 1);
      end else begin
        if (req_valid && req_ready) begin
          last_hs = cyc;
          if (req_write) begin
            writes++;
            if (req_wdata != 8'hF0 || req_addr != addr) bad_wr = 1;
          end else begin
            reads++;
            chk(req_addr == addr, "R3 read address", int'(req_addr), int'(addr));
            pend = lat;
          end
        end
        if (rsp_valid && rsp_ready) begin last_hs = cyc; rsp_hs_prev = 1; end
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0;
    chk(got_done, "R11 done seen (watchdog)", int'(got_done), 1);
    chk(pass == exp_pass && fail == !exp_pass,
        tog ? "R7/R8 toggle verdict" : "R4/R5/R6 data verdict", int'(pass), int'(exp_pass));
    chk(timeout == exp_to, "R9 timeout flag", int'(timeout), int'(exp_to));
    chk(reads == exp_reads, exp_to ? "R9 read count" : "R5/R8 read count", reads, exp_reads);
    chk(writes == ((!exp_pass && rof) ? 1 : 0), "R10 reset write count", writes,
        (!exp_pass && rof) ? 1 : 0);
    chk(!bad_wr, "R10 reset write content", int'(bad_wr), 0);
    repeat (3) @(negedge clk);
    chk(!busy && !req_valid, "R2 idle after done, late start ignored", int'(busy), 0);
    chk(pass == exp_pass && !done, "R11 verdict held", int'(pass), int'(exp_pass));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !fail && !timeout && !req_valid && !rsp_ready,
        "R1 reset state", int'({busy, done, pass, fail, timeout, req_valid, rsp_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req_valid, "R1 idle after reset release", int'(busy), 0);

    for (int tog = 0; tog < 2; tog++)
      for (int nb = 0; nb < 6; nb++)
        for (int endk = 0; endk < 3; endk++)
          for (int e7 = 0; e7 < 2; e7++)
            for (int rof = 0; rof < 2; rof++)
              for (int st = 0; st < 2; st++) begin
                // build the status script
                logic ev;
                ev = e7[0];
                for (int k = 0; k < 16; k++) script[k] = 8'h00;
                if (tog == 0) begin
                  for (int k = 0; k < nb; k++)
                    script[k] = {~ev, k[0], 1'b0, 5'(k * 7)};
                  if (endk == 0)      script[nb] = {ev, 7'h35};
                  else begin
                    script[nb]     = {~ev, 7'h2A};
                    script[nb + 1] = (endk == 1) ? {ev, 7'h20} : {~ev, 7'h20};
                  end
                end else begin
                  for (int k = 0; k <= nb; k++)
                    script[k] = {ev, k[0] ^ ev, 1'b0, 5'(k * 3)};
                  if (endk == 0) script[nb + 1] = {~ev, script[nb][6], 1'b1, 5'h11};
                  else begin
                    script[nb + 1] = {ev, ~script[nb][6], 1'b1, 5'h02};
                    script[nb + 2] = {~ev, ev, 1'b0, 5'h09};
                    script[nb + 3] = (endk == 1) ? {ev, ev, 1'b1, 5'h04}
                                                 : {ev, ~ev, 1'b0, 5'h04};
                  end
                end
                run_case(tog[0], ev, nb, endk, rof[0], st[0], 1 + ((nb + endk) % 2));
              end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule